// File: doc/BRIEF.md
# Charge-Balanced Integrator Averaging Engine

This block is the digital half of a sampler that reports the mean of an input signal over each carrier period. An external analog integrator accumulates the input together with a balancing voltage from a small D/A converter. An ADC reads the integrator output once per carrier period. From each new reading, the previous reading and the balancing word that was in force during the period, the block reconstructs the period-average of the input. It then issues the next balancing word. That word is the rounded, negated previous output times the integration scale factor, so the integrator is driven back toward zero every period. The mean it reports belongs to the middle of the integration window, which gives half a carrier period of feedback delay.

The scale factor g = RC/Ts is not a fixed constant. After reset the block asks for a known calibration input through `cal_busy` and holds the balancing word at zero. It records the integrator output at the first sample and again CAL_PERIODS samples later. It then divides the known total charge by the measured output swing to obtain g as an unsigned Q2.14 value. The D/A word may have low resolution. The rounding left over in one period stays in the integrator and is accounted for in the next, because the average always uses the word that was actually applied.

Integrator model assumed throughout: y(k) = y(k-1) - (x(k) - w(k)) / g. Here x is the mean input of period k, w(k) is the balancing word applied during period k, and y is the integrator output in ADC codes.

Top module: `chg_bal_avg`

## Requirements
- R1: While reset is held and right after it is released: `dac_word`=0, `avg_word`=0, `avg_vld`=0, `dac_sat`=0, `cal_done`=0 and `cal_busy`=1.
- R2: Until calibration completes, `dac_word` stays 0 and `avg_vld` never pulses, for any sample strobe.
- R3: With y_first as the first sample after reset and y_last as the sample CAL_PERIODS strobes later, `gain_q` becomes floor(CAL_PERIODS*CAL_REF*2^14 / (y_first - y_last)). Within the cycles of the division, `cal_done` rises and `cal_busy` falls. After that, `gain_q` and `cal_done` never change.
- R4: The first sample strobe after calibration does not pulse `avg_vld` and leaves `avg_word` unchanged. It does load a new balancing word.
- R5: Every later sample strobe pulses `avg_vld` for exactly one cycle, in the cycle after the strobe. At the same time `avg_word` = rnd(g*(y_prev - y_new)) + w_applied, where rnd(p) = floor((p + 2^13) / 2^14).
- R6: On each post-calibration strobe, `dac_word` becomes -rnd(g*y_new), clipped per R7, together with `avg_word`.
- R7: `dac_word` is clipped to the signed DAC_W-bit range, [-512, 511] at default width.
- R8: `dac_sat` goes to 1 on any strobe whose balancing word had to be clipped, and it stays 1 until reset.
- R9: With the integrator model above, `avg_word` is within 3 codes of the true period mean. This holds also in periods where the balancing word is clipped.
- R10: `avg_word` and `dac_word` hold their values in every cycle that does not follow a sample strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe, once per carrier period, when `smp_data` is valid |
| smp_data | input | ADC_W | Signed integrator output sample from the ADC |
| cal_busy | output | 1 | High while the calibration input must be applied to the integrator |
| cal_done | output | 1 | High once the scale factor is measured |
| gain_q | output | GAIN_W | Measured RC/Ts, unsigned Q2.14 |
| dac_word | output | DAC_W | Signed balancing word for the D/A converter |
| dac_sat | output | 1 | Sticky flag: a balancing word was clipped |
| avg_word | output | ADC_W+GAIN_W+3-FRAC | Signed period-average of the input |
| avg_vld | output | 1 | One-cycle strobe when `avg_word` and `dac_word` update |

## Verification
The bench models the integrator with a non-integer gain. The measured Q2.14 factor is therefore inexact, and a divider that truncated the wrong way or dropped a bit would miss the expected quotient. It drives two consecutive periods far above the D/A range and then lets the integrator unwind. A design that averaged with the unclipped word instead of the applied one would report an error of hundreds of codes there, and one that cleared the sticky flag would be caught after recovery. The priming sample after calibration is checked for the absence of a strobe, which catches an engine that differences a calibration-period sample against normal input. Steady periods with mixed signs test the round-half-up product and the sign of the balancing word.

// File: rtl/cba_pkg.sv
// Shared types for the charge-balanced averaging engine.
package cba_pkg;

    // Sequencer phases: calibration capture, division, priming, normal run.
    typedef enum logic [2:0] {
        ST_CAL0  = 3'd0,
        ST_CAL   = 3'd1,
        ST_DIV   = 3'd2,
        ST_PRIME = 3'd3,
        ST_RUN   = 3'd4
    } cba_state_e;

endpackage

// File: rtl/cba_rmul.sv
// Signed sample times unsigned fixed-point gain, rounded to nearest
// (half rounds up) at FRAC fractional bits. Purely combinational.
// Assumes the product plus half an LSB does not overflow P_W bits.
module cba_rmul #(
    parameter  int A_W  = 17,
    parameter  int G_W  = 16,
    parameter  int FRAC = 14,
    localparam int P_W  = A_W + G_W + 1,
    localparam int O_W  = P_W - FRAC
) (
    input  logic signed [A_W-1:0] a,
    input  logic        [G_W-1:0] g,
    output logic signed [O_W-1:0] y
);
    localparam logic signed [P_W-1:0] HALF = P_W'(1) << (FRAC - 1);

    logic signed [P_W-1:0] prod;
    logic signed [P_W-1:0] biased;

    // Full-width product, then bias by half an LSB and drop the fraction.
    assign prod   = a * $signed({1'b0, g});
    assign biased = prod + HALF;
    assign y      = biased[P_W-1:FRAC];
endmodule

// File: rtl/cba_sat.sv
// Clips a signed value into a narrower signed range and flags a clip.
// When the output is at least as wide as the input it sign-extends.
module cba_sat #(
    parameter int IN_W  = 20,
    parameter int OUT_W = 10
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout,
    output logic                    hit
);
    generate
        if (IN_W > OUT_W) begin : g_clip
            localparam logic signed [IN_W-1:0] HI = IN_W'(2 ** (OUT_W - 1) - 1);
            localparam logic signed [IN_W-1:0] LO = ~HI;
            // Compare against both rails and pick the limit when outside.
            always_comb begin
                if (din > HI) begin
                    dout = HI[OUT_W-1:0];
                    hit  = 1'b1;
                end else if (din < LO) begin
                    dout = LO[OUT_W-1:0];
                    hit  = 1'b1;
                end else begin
                    dout = din[OUT_W-1:0];
                    hit  = 1'b0;
                end
            end
        end else begin : g_pass
            assign dout = OUT_W'(din);
            assign hit  = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/cba_cal_div.sv
// Serial restoring divider for the calibration scale factor.
// quo = floor(num / den), one quotient bit per cycle, Q_W cycles.
// If den is zero or the quotient would not fit in Q_W bits, it returns
// all ones on the cycle after go. done pulses once when quo is valid.
// Assumes go is not raised again while a division is in progress.
module cba_cal_div #(
    parameter int NUM_W = 33,
    parameter int DEN_W = 17,
    parameter int Q_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [Q_W-1:0]   quo
);
    localparam int HI_W  = NUM_W - Q_W;
    localparam int CMP_W = (HI_W > DEN_W) ? HI_W : DEN_W;
    localparam int CNT_W = $clog2(Q_W + 1);

    logic [HI_W-1:0]  num_hi;
    logic [DEN_W-1:0] rem;
    logic [Q_W-1:0]   sh;
    logic [CNT_W-1:0] cnt;
    logic             busy;
    logic [DEN_W:0]   trial;
    logic             q_bit;
    logic [DEN_W:0]   trial_sub;

    assign num_hi    = num[NUM_W-1:Q_W];
    assign trial     = {rem, sh[Q_W-1]};
    assign q_bit     = (trial >= {1'b0, den});
    assign trial_sub = trial - {1'b0, den};
    assign quo       = sh;

    // Load the operands, then shift quotient bits in as numerator bits leave.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            sh   <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                if (den == '0 || CMP_W'(num_hi) >= CMP_W'(den)) begin
                    sh   <= '1;
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    rem  <= DEN_W'(num_hi);
                    sh   <= num[Q_W-1:0];
                    cnt  <= CNT_W'(Q_W);
                    busy <= 1'b1;
                end
            end else if (busy) begin
                rem <= q_bit ? trial_sub[DEN_W-1:0] : trial[DEN_W-1:0];
                sh  <= {sh[Q_W-2:0], q_bit};
                cnt <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/chg_bal_avg.sv
// Charge-balanced integrator averaging engine.
// After reset it requests the calibration input (cal_busy) with the
// balancing word held at zero, and records the integrator output at the
// first strobe and CAL_PERIODS strobes later. It divides the known charge
// CAL_PERIODS*CAL_REF by that swing to get RC/Ts in Q2.14. After that,
// every strobe yields the period mean
//     avg = rnd(g*(y_prev - y_new)) + w_applied
// and the next balancing word w = sat(-rnd(g*y_new)).
// Assumes: strobes are at least Q_W+3 cycles apart, the ADC and the D/A
// share one code scale, and the integrator obeys
//     y(k) = y(k-1) - (x - w)/g.
module chg_bal_avg #(
    parameter  int ADC_W       = 16,
    parameter  int DAC_W       = 10,
    parameter  int GAIN_W      = 16,
    parameter  int FRAC        = 14,
    parameter  int CAL_PERIODS = 4,
    parameter  int CAL_REF     = 100,
    localparam int AVG_W       = ADC_W + GAIN_W + 3 - FRAC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_stb,
    input  logic signed [ADC_W-1:0] smp_data,
    output logic                    cal_busy,
    output logic                    cal_done,
    output logic [GAIN_W-1:0]       gain_q,
    output logic signed [DAC_W-1:0] dac_word,
    output logic                    dac_sat,
    output logic signed [AVG_W-1:0] avg_word,
    output logic                    avg_vld
);
    import cba_pkg::*;

    localparam int DIFF_W = ADC_W + 1;
    localparam int DM_W   = DIFF_W + GAIN_W + 1 - FRAC;
    localparam int WM_W   = ADC_W + GAIN_W + 1 - FRAC;
    localparam int CNT_W  = $clog2(CAL_PERIODS) + 1;
    localparam int NUM_W  = ADC_W + CNT_W + FRAC;
    localparam logic [NUM_W-1:0] NUMER = NUM_W'(CAL_PERIODS * CAL_REF) << FRAC;

    cba_state_e               state;
    logic signed [ADC_W-1:0]  y_prev;
    logic signed [ADC_W-1:0]  y_first;
    logic [CNT_W-1:0]         cal_cnt;
    logic [DIFF_W-1:0]        den_r;
    logic                     div_go;
    logic                     div_done;
    logic [GAIN_W-1:0]        div_quo;
    logic signed [DIFF_W-1:0] run_diff;
    logic signed [DIFF_W-1:0] cal_diff;
    logic signed [DM_W-1:0]   dm_out;
    logic signed [WM_W-1:0]   wm_out;
    logic signed [WM_W:0]     w_neg;
    logic signed [DAC_W-1:0]  w_next;
    logic                     w_hit;
    logic signed [AVG_W-1:0]  avg_calc;

    // Output swing over the period just ended, and over the calibration span.
    assign run_diff = DIFF_W'(y_prev)  - DIFF_W'(smp_data);
    assign cal_diff = DIFF_W'(y_first) - DIFF_W'(smp_data);

    cba_rmul #(.A_W(DIFF_W), .G_W(GAIN_W), .FRAC(FRAC)) u_mul_avg (
        .a (run_diff),
        .g (gain_q),
        .y (dm_out)
    );

    cba_rmul #(.A_W(ADC_W), .G_W(GAIN_W), .FRAC(FRAC)) u_mul_bal (
        .a (smp_data),
        .g (gain_q),
        .y (wm_out)
    );

    // The balancing word opposes the charge now held on the integrator.
    assign w_neg = -(WM_W + 1)'(wm_out);

    cba_sat #(.IN_W(WM_W + 1), .OUT_W(DAC_W)) u_sat (
        .din  (w_neg),
        .dout (w_next),
        .hit  (w_hit)
    );

    // The mean adds back the word that was in force during the period.
    assign avg_calc = AVG_W'(dm_out) + AVG_W'(dac_word);

    cba_cal_div #(.NUM_W(NUM_W), .DEN_W(DIFF_W), .Q_W(GAIN_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (NUMER),
        .den   (den_r),
        .done  (div_done),
        .quo   (div_quo)
    );

    assign cal_busy = !cal_done;

    // Sequencer: calibration capture, division, priming, then per-period update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_CAL0;
            y_prev   <= '0;
            y_first  <= '0;
            cal_cnt  <= '0;
            den_r    <= '0;
            div_go   <= 1'b0;
            gain_q   <= '0;
            cal_done <= 1'b0;
            dac_word <= '0;
            dac_sat  <= 1'b0;
            avg_word <= '0;
            avg_vld  <= 1'b0;
        end else begin
            avg_vld <= 1'b0;
            div_go  <= 1'b0;
            case (state)
                ST_CAL0: if (smp_stb) begin
                    y_first <= smp_data;
                    cal_cnt <= '0;
                    state   <= ST_CAL;
                end
                ST_CAL: if (smp_stb) begin
                    if (cal_cnt == CNT_W'(CAL_PERIODS - 1)) begin
                        den_r  <= (cal_diff > 0) ? cal_diff : '0;
                        div_go <= 1'b1;
                        state  <= ST_DIV;
                    end else begin
                        cal_cnt <= cal_cnt + 1'b1;
                    end
                end
                ST_DIV: if (div_done) begin
                    gain_q   <= div_quo;
                    cal_done <= 1'b1;
                    state    <= ST_PRIME;
                end
                ST_PRIME: if (smp_stb) begin
                    y_prev   <= smp_data;
                    dac_word <= w_next;
                    dac_sat  <= dac_sat | w_hit;
                    state    <= ST_RUN;
                end
                ST_RUN: if (smp_stb) begin
                    y_prev   <= smp_data;
                    dac_word <= w_next;
                    dac_sat  <= dac_sat | w_hit;
                    avg_word <= avg_calc;
                    avg_vld  <= 1'b1;
                end
                default: state <= ST_CAL0;
            endcase
        end
    end
endmodule

// File: rtl/chg_bal_avg_chk.sv
// Protocol checks for chg_bal_avg, attached with bind below.
module chg_bal_avg_chk #(
    parameter int DAC_W  = 10,
    parameter int GAIN_W = 16,
    parameter int AVG_W  = 21
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    smp_stb,
    input logic                    avg_vld,
    input logic                    cal_done,
    input logic [GAIN_W-1:0]       gain_q,
    input logic signed [DAC_W-1:0] dac_word,
    input logic                    dac_sat,
    input logic signed [AVG_W-1:0] avg_word
);
    // R2: no average strobe before calibration
    assert_no_avg_uncal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_done |-> !avg_vld);

    // R2: balancing word idle before calibration
    assert_dac_idle_uncal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_done |-> dac_word == '0);

    // R3: scale factor frozen once calibrated
    assert_gain_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> (cal_done && $stable(gain_q)));

    // R5: strobe only follows a sample taken while calibrated
    assert_vld_after_stb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        avg_vld |-> ($past(smp_stb) && $past(cal_done)));

    // R8: saturation flag is sticky
    assert_sat_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sat |=> dac_sat);

    // R10: outputs hold when no strobe was taken
    assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smp_stb) |-> ($stable(avg_word) && $stable(dac_word)));
endmodule

bind chg_bal_avg chg_bal_avg_chk #(
    .DAC_W  (DAC_W),
    .GAIN_W (GAIN_W),
    .AVG_W  (AVG_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_stb  (smp_stb),
    .avg_vld  (avg_vld),
    .cal_done (cal_done),
    .gain_q   (gain_q),
    .dac_word (dac_word),
    .dac_sat  (dac_sat),
    .avg_word (avg_word)
);

// File: tb/tb_chg_bal_avg.sv
// Directed bench: behavioural integrator with g = 1.3, one task per scenario.
module tb_chg_bal_avg;
    localparam int  CLK_PERIOD = 10;
    localparam int  GAP        = 40;
    localparam int  NPER       = 4;
    localparam int  CREF       = 100;
    localparam real G_TRUE     = 1.3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_stb = 1'b0;
    logic signed [15:0] smp_data = '0;
    logic               cal_busy, cal_done, dac_sat, avg_vld;
    logic [15:0]        gain_q;
    logic signed [9:0]  dac_word;
    logic signed [20:0] avg_word;

    int  n_chk = 0;
    int  n_err = 0;
    bit  finished = 1'b0;
    real y_mod = 0.0;
    int  prev_s = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    chg_bal_avg #(.CAL_PERIODS(NPER), .CAL_REF(CREF)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_stb  (smp_stb),
        .smp_data (smp_data),
        .cal_busy (cal_busy),
        .cal_done (cal_done),
        .gain_q   (gain_q),
        .dac_word (dac_word),
        .dac_sat  (dac_sat),
        .avg_word (avg_word),
        .avg_vld  (avg_vld)
    );

    function automatic longint rnd(input longint p);
        return (p + 64'sd8192) >>> 14;
    endfunction

    function automatic longint clip(input longint v);
        if (v > 511) return 511;
        if (v < -512) return -512;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One carrier period: integrate x with the applied word, strobe the sample.
    task automatic interval(input int x, output int s);
        int w;
        w = int'(dac_word);
        y_mod = y_mod - (real'(x) - real'(w)) / G_TRUE;
        if (y_mod > 32767.0) y_mod = 32767.0;
        if (y_mod < -32768.0) y_mod = -32768.0;
        s = int'(y_mod);
        smp_data = 16'(s);
        smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    // Normal period with the full set of output checks.
    task automatic step_run(input int x);
        int s;
        longint w_old, g, e_avg, e_w;
        w_old = longint'(dac_word);
        g     = longint'(gain_q);
        interval(x, s);
        e_avg = rnd(g * (prev_s - s)) + w_old;
        e_w   = clip(-rnd(g * s));
        chk(avg_vld == 1'b1, "R5 strobe", avg_vld, 1);
        chk(longint'(avg_word) == e_avg, "R5 average", avg_word, e_avg);
        chk(longint'(dac_word) == e_w, "R6 balancing word", dac_word, e_w);
        chk(longint'(avg_word) - x <= 3 && x - longint'(avg_word) <= 3,
            "R9 accuracy", avg_word, x);
        prev_s = s;
        @(negedge clk);
        chk(avg_vld == 1'b0, "R5 single-cycle strobe", avg_vld, 0);
        repeat (GAP) @(negedge clk);
        chk(longint'(avg_word) == e_avg, "R10 hold average", avg_word, e_avg);
        chk(longint'(dac_word) == e_w, "R10 hold word", dac_word, e_w);
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        chk(dac_word == '0, "R1 dac_word", dac_word, 0);
        chk(avg_word == '0, "R1 avg_word", avg_word, 0);
        chk(avg_vld == 1'b0, "R1 avg_vld", avg_vld, 0);
        chk(dac_sat == 1'b0, "R1 dac_sat", dac_sat, 0);
        chk(cal_done == 1'b0, "R1 cal_done", cal_done, 0);
        chk(cal_busy == 1'b1, "R1 cal_busy", cal_busy, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cal_busy == 1'b1 && dac_word == '0, "R1 after release", cal_busy, 1);
    endtask

    task automatic t_calibrate();
        int s, y_first, y_last;
        longint e_g;
        y_first = 0;
        y_last  = 0;
        for (int i = 0; i <= NPER; i++) begin
            interval(CREF, s);
            if (i == 0) y_first = s;
            y_last = s;
            chk(avg_vld == 1'b0, "R2 no strobe", avg_vld, 0);
            chk(dac_word == '0, "R2 word idle", dac_word, 0);
            repeat (GAP) @(negedge clk);
        end
        e_g = (longint'(NPER) * CREF * 16384) / (y_first - y_last);
        chk(cal_done == 1'b1, "R3 cal_done", cal_done, 1);
        chk(cal_busy == 1'b0, "R3 cal_busy", cal_busy, 0);
        chk(longint'(gain_q) == e_g, "R3 gain", gain_q, e_g);
    endtask

    task automatic t_prime();
        int s;
        longint e_w;
        interval(0, s);
        e_w = clip(-rnd(longint'(gain_q) * s));
        chk(avg_vld == 1'b0, "R4 no strobe", avg_vld, 0);
        chk(avg_word == '0, "R4 average unchanged", avg_word, 0);
        chk(longint'(dac_word) == e_w, "R4 word loaded", dac_word, e_w);
        prev_s = s;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic t_steady();
        step_run(200);
        step_run(-350);
        step_run(0);
        step_run(450);
        step_run(123);
        step_run(-77);
        chk(dac_sat == 1'b0, "R8 flag clear without clipping", dac_sat, 0);
    endtask

    task automatic t_saturate();
        step_run(900);
        chk(longint'(dac_word) == 511, "R7 upper clip", dac_word, 511);
        chk(dac_sat == 1'b1, "R8 flag set", dac_sat, 1);
        step_run(900);
        chk(longint'(dac_word) == 511, "R7 upper clip again", dac_word, 511);
        for (int i = 0; i < 4; i++) step_run(0);
        chk(dac_sat == 1'b1, "R8 flag sticky", dac_sat, 1);
        step_run(-900);
        chk(longint'(dac_word) == -512, "R7 lower clip", dac_word, -512);
        step_run(-300);
        step_run(250);
    endtask

    initial begin
        t_reset();
        t_calibrate();
        t_prime();
        t_steady();
        t_saturate();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule